// File: doc/BRIEF.md
# Vector Component Branch Evaluator

This block decides, in the same cycle an instruction is presented, whether program flow leaves the sequential path, and it supplies the program counter for the next instruction. Conditional jumps compare one lane of two packed three-lane vector operands. Two opcode fields control the comparison: bits 4:3 choose the lane and bits 2:0 choose the relation. The unconditional jump goes to the destination field of the instruction. The return instruction goes to a single saved return address.

The return address register is the only state in the block. A call strobe writes `pc + 1` into it on the next rising clock edge. The taken flag and the next program counter are combinational functions of the inputs and of that register. Instruction fetch, the register file and arithmetic units sit outside the block.

Top module: `bev_branch_unit`

## Requirements
- R1: The lane compared is selected by opcode bits 4:3: 01 selects lane x (source bits 31:0), 10 selects lane y (bits 63:32) and 11 selects lane z (bits 95:64).
- R2: Opcode bits 2:0 select the relation A ? B: 000 A>B, 001 A<B, 010 A==B, 011 A!=B, 100 A>=B, 101 A<=B. Lanes are compared as signed two's complement.
- R3: Opcodes 0–63 that are not conditional jumps are never taken. This covers codes 14, 15, 22, 23, 30 and 31, and every code with bit 5 set. The conditional jumps are codes 8–13, 16–21 and 24–29.
- R4: A conditional jump whose relation holds asserts `taken_o` and drives `next_pc_o` to `dst_i`.
- R5: Whenever `taken_o` is low, `next_pc_o` equals `pc_i + 1` modulo 2^16, so 0xFFFF goes to 0x0000.
- R6: Opcode 0x58 (unconditional jump) is always taken, with `next_pc_o` = `dst_i`.
- R7: Opcode 0x40 (return) is always taken, with `next_pc_o` equal to the saved return address.
- R8: When `call_i` is high at a rising edge, the return register captures `pc_i + 1`. A return presented in that same cycle still sees the previous saved value.
- R9: Reset clears the saved return address to 0x0000. Reset is asynchronous, active low and released synchronously.
- R10: Opcodes 64–127 other than 0x40 and 0x58 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 7 | Instruction opcode |
| src_a_i | input | 96 | First vector operand, three 32-bit lanes |
| src_b_i | input | 96 | Second vector operand, three 32-bit lanes |
| dst_i | input | 16 | Destination field, used as the jump target |
| pc_i | input | 16 | Current program counter |
| call_i | input | 1 | Strobe that saves `pc_i + 1` as the return address |
| taken_o | output | 1 | Flow leaves the sequential path |
| next_pc_o | output | 16 | Program counter of the next instruction |

## Verification
The call strobe and a return instruction can arrive in the same cycle. The return must read the old saved address, and the new `pc + 1` becomes visible only from the following cycle. The bench first stores a known address. It then drives `call_i` together with opcode 0x40 at a fresh `pc`, checks that `next_pc_o` still shows the first address, and on the next cycle checks that it shows the new address. The exhaustive opcode sweep puts the compared values in the chosen lane and swapped values in the other lanes, so a wrong lane choice changes the taken result.

// File: rtl/bev_pkg.sv
package bev_pkg;
  localparam int OP_W   = 7;
  localparam int LANES  = 3;
  localparam int LANE_W = 32;
  localparam int SEL_W  = 2;

  localparam logic [OP_W-1:0] OP_RETURN = 7'h40;
  localparam logic [OP_W-1:0] OP_JUMP   = 7'h58;

  typedef enum logic [2:0] {
    REL_GT = 3'd0,
    REL_LT = 3'd1,
    REL_EQ = 3'd2,
    REL_NE = 3'd3,
    REL_GE = 3'd4,
    REL_LE = 3'd5
  } rel_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_COND = 2'd1,
    KIND_JUMP = 2'd2,
    KIND_RET  = 2'd3
  } kind_e;
endpackage

// File: rtl/bev_decode.sv
module bev_decode
  import bev_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  output kind_e            kind,
  output logic [SEL_W-1:0] lane_sel,
  output rel_e             rel
);
  logic fam_ok;
  logic rel_ok;

  always_comb begin
    fam_ok   = (op[6:5] == 2'b00) && (op[4:3] != 2'b00);
    rel_ok   = (op[2:0] <= 3'd5);
    lane_sel = SEL_W'(op[4:3] - 2'd1);
    rel      = rel_e'(op[2:0]);
    if (op == OP_RETURN)        kind = KIND_RET;
    else if (op == OP_JUMP)     kind = KIND_JUMP;
    else if (fam_ok && rel_ok)  kind = KIND_COND;
    else                        kind = KIND_NONE;
  end
endmodule

// File: rtl/bev_compare.sv
module bev_compare
  import bev_pkg::*;
#(
  parameter int N_LANE  = LANES,
  parameter int W_LANE  = LANE_W,
  parameter int W_SEL   = SEL_W,
  localparam int VEC_W  = N_LANE * W_LANE
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [W_SEL-1:0] sel,
  input  rel_e             rel,
  output logic             hit
);
  logic signed [W_LANE-1:0] a_lane [N_LANE];
  logic signed [W_LANE-1:0] b_lane [N_LANE];
  logic signed [W_LANE-1:0] sa;
  logic signed [W_LANE-1:0] sb;
  logic gt, lt, eq;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    assign a_lane[g] = a[g*W_LANE +: W_LANE];
    assign b_lane[g] = b[g*W_LANE +: W_LANE];
  end

  always_comb begin
    sa = a_lane[0];
    sb = b_lane[0];
    for (int i = 0; i < N_LANE; i++) begin
      if (W_SEL'(i) == sel) begin
        sa = a_lane[i];
        sb = b_lane[i];
      end
    end
    gt = (sa > sb);
    lt = (sa < sb);
    eq = (sa == sb);
    case (rel)
      REL_GT:  hit = gt;
      REL_LT:  hit = lt;
      REL_EQ:  hit = eq;
      REL_NE:  hit = !eq;
      REL_GE:  hit = gt || eq;
      REL_LE:  hit = lt || eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bev_retaddr.sv
module bev_retaddr #(
  parameter int W_PC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic [W_PC-1:0] pc_i,
  output logic [W_PC-1:0] ret_q,
  output logic            rst_ok
);
  logic [1:0]      sync_q;
  logic [W_PC-1:0] ret_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ok = sync_q[1];

  always_comb begin
    ret_d = ret_q;
    if (call_i) ret_d = pc_i + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) ret_q <= '0;
    else         ret_q <= ret_d;
  end

  // R8: a call strobe saves the incremented pc for the next cycle
  p_call_capture_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    call_i |=> (ret_q == W_PC'($past(pc_i) + 1'b1)));
  // R8: without a call the saved address holds
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !call_i |=> $stable(ret_q));
endmodule

// File: rtl/bev_branch_unit.sv
module bev_branch_unit
  import bev_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int N_LANE = LANES,
  parameter int W_LANE = LANE_W,
  localparam int VEC_W = N_LANE * W_LANE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [PC_W-1:0]  dst_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             call_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);
  kind_e            kind;
  logic [SEL_W-1:0] lane_sel;
  rel_e             rel;
  logic             hit;
  logic [PC_W-1:0]  ret_q;
  logic             rst_ok;
  logic [PC_W-1:0]  pc_inc;

  bev_decode u_decode (
    .op       (op_i),
    .kind     (kind),
    .lane_sel (lane_sel),
    .rel      (rel)
  );

  bev_compare #(.N_LANE(N_LANE), .W_LANE(W_LANE), .W_SEL(SEL_W)) u_compare (
    .a   (src_a_i),
    .b   (src_b_i),
    .sel (lane_sel),
    .rel (rel),
    .hit (hit)
  );

  bev_retaddr #(.W_PC(PC_W)) u_ret (
    .clk    (clk),
    .rst_n  (rst_n),
    .call_i (call_i),
    .pc_i   (pc_i),
    .ret_q  (ret_q),
    .rst_ok (rst_ok)
  );

  always_comb begin
    pc_inc    = pc_i + 1'b1;
    taken_o   = 1'b0;
    next_pc_o = pc_inc;
    case (kind)
      KIND_COND: if (hit) begin
        taken_o   = 1'b1;
        next_pc_o = dst_i;
      end
      KIND_JUMP: begin
        taken_o   = 1'b1;
        next_pc_o = dst_i;
      end
      KIND_RET: begin
        taken_o   = 1'b1;
        next_pc_o = ret_q;
      end
      default: ;
    endcase
  end

  // R3: non-jump codes in the lower half never branch
  p_nonjump_quiet_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    ((op_i[6] == 1'b0) && (op_i[5] || (op_i[4:3] == 2'b00) || (op_i[2:0] > 3'd5)))
      |-> !taken_o);
  // R5: fall-through always advances by one
  p_fallthrough_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    !taken_o |-> (next_pc_o == PC_W'(pc_i + 1'b1)));
  // R6: unconditional jump lands on the destination field
  p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i == OP_JUMP) |-> (taken_o && (next_pc_o == dst_i)));
  // R10: upper-half codes other than jump and return never branch
  p_typeii_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i[6] && (op_i != OP_JUMP) && (op_i != OP_RETURN)) |-> !taken_o);
endmodule

// File: tb/tb_bev_branch_unit.sv
module tb_bev_branch_unit;
  logic        clk;
  logic        rst_n;
  logic [6:0]  op_i;
  logic [95:0] src_a_i, src_b_i;
  logic [15:0] dst_i, pc_i;
  logic        call_i;
  logic        taken_o;
  logic [15:0] next_pc_o;

  int tests = 0;
  int fails = 0;
  logic [15:0] ret_model;

  bev_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .dst_i(dst_i), .pc_i(pc_i), .call_i(call_i), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [16:0] model(input logic [6:0] op, input logic [95:0] a, b,
                                        input logic [15:0] dst, pc);
    logic cond;
    int lane;
    int relc;
    logic signed [31:0] x, y;
    logic t;
    cond = (op >= 8 && op <= 13) || (op >= 16 && op <= 21) || (op >= 24 && op <= 29);
    t = 1'b0;
    if (op == 7'd64) return {1'b1, ret_model};
    if (op == 7'd88) return {1'b1, dst};
    if (cond) begin
      lane = int'(op) / 8 - 1;
      relc = int'(op) % 8;
      x = a[lane*32 +: 32];
      y = b[lane*32 +: 32];
      case (relc)
        0: t = x > y;
        1: t = x < y;
        2: t = x == y;
        3: t = x != y;
        4: t = x >= y;
        default: t = x <= y;
      endcase
    end
    return t ? {1'b1, dst} : {1'b0, 16'(pc + 16'd1)};
  endfunction

  task automatic check_now(input string tag);
    logic [16:0] e;
    e = model(op_i, src_a_i, src_b_i, dst_i, pc_i);
    tests++;
    if (taken_o !== e[16] || next_pc_o !== e[15:0]) begin
      fails++;
      $display("FAIL %s op=%0d taken=%b exp=%b next_pc=%h exp=%h",
               tag, op_i, taken_o, e[16], next_pc_o, e[15:0]);
    end
  endtask

  task automatic drive(input logic [6:0] op, input logic [95:0] a, b,
                       input logic [15:0] dst, pc, input logic call);
    @(negedge clk);
    op_i = op; src_a_i = a; src_b_i = b; dst_i = dst; pc_i = pc; call_i = call;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    call_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ret_model = 16'h0000;
  endtask

  function automatic string tag_for(input logic [6:0] op, input logic t);
    if (op == 7'd64) return "R7";
    if (op == 7'd88) return "R6";
    if (op >= 7'd64) return "R10";
    if ((op >= 8 && op <= 13) || (op >= 16 && op <= 21) || (op >= 24 && op <= 29))
      return t ? "R1/R2/R4" : "R1/R2/R5";
    return "R3";
  endfunction

  initial begin
    logic signed [31:0] va [5];
    logic signed [31:0] vb [5];
    logic [95:0] a, b;
    logic [16:0] e;
    va[0] = 32'sd5;          vb[0] = 32'sd5;
    va[1] = 32'sd7;          vb[1] = -32'sd2;
    va[2] = -32'sd2;         vb[2] = 32'sd7;
    va[3] = 32'h8000_0000;   vb[3] = 32'h7FFF_FFFF;
    va[4] = 32'h7FFF_FFFF;   vb[4] = 32'h8000_0000;
    op_i = '0; src_a_i = '0; src_b_i = '0; dst_i = '0; pc_i = '0; call_i = 1'b0;
    ret_model = 16'h0000;
    do_reset();

    // R9: saved address is zero after reset
    drive(7'd64, '0, '0, 16'h5555, 16'h0010, 1'b0);
    check_now("R9");

    // R8: call saves pc+1
    drive(7'd0, '0, '0, 16'h0, 16'h1233, 1'b1);
    drive(7'd64, '0, '0, 16'h0, 16'h0300, 1'b0);
    ret_model = 16'h1234;
    check_now("R8");

    // R8: call and return in the same cycle: return sees the old value
    drive(7'd64, '0, '0, 16'h0, 16'h2000, 1'b1);
    check_now("R8");
    drive(7'd64, '0, '0, 16'h0, 16'h0400, 1'b0);
    ret_model = 16'h2001;
    check_now("R8");

    // R8: call with pc at top of range wraps the saved address
    drive(7'd0, '0, '0, 16'h0, 16'hFFFF, 1'b1);
    drive(7'd64, '0, '0, 16'h0, 16'h0500, 1'b0);
    ret_model = 16'h0000;
    check_now("R8");

    drive(7'd0, '0, '0, 16'h0, 16'h1233, 1'b1);
    drive(7'd0, '0, '0, 16'h0, 16'h0000, 1'b0);
    ret_model = 16'h1234;

    // Exhaustive opcode sweep; chosen lane gets the pair, others get it swapped
    for (int op = 0; op < 128; op++) begin
      for (int k = 0; k < 3; k++) begin
        for (int p = 0; p < 5; p++) begin
          for (int l = 0; l < 3; l++) begin
            a[l*32 +: 32] = (l == k) ? va[p] : vb[p];
            b[l*32 +: 32] = (l == k) ? vb[p] : va[p];
          end
          drive(7'(op), a, b, 16'(16'hA000 + op * 8 + k),
                (p == 0) ? 16'hFFFF : 16'(16'h0100 + op), 1'b0);
          e = model(op_i, src_a_i, src_b_i, dst_i, pc_i);
          check_now(tag_for(7'(op), e[16]));
        end
      end
    end

    // R9: reset mid-run clears the saved address again
    do_reset();
    drive(7'd64, '0, '0, 16'h7777, 16'h0020, 1'b0);
    check_now("R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule